// File: doc/BRIEF.md
# Channel Address Interleave Remover

This block turns a system physical address into the address seen by one memory channel. A caller presents an address, a channel number and a start pulse. The block then searches eight programmed target ranges for the one that holds the address, and takes that range's socket and channel interleave settings. It subtracts the channel's offset for that range and removes the interleave bits in two steps, one for the socket interleave and one for the channel interleave. The range, wayness and offset register contents arrive as flat input vectors. Loading them is done elsewhere.

Each step shifts the running address right by a granularity, divides by a way count, shifts it back and restores the low bits. The socket ways are always a power of two, so a shift removes them. The channel ways may be three. In that case a serial divide-by-three unit runs for one cycle per address bit. Normally the socket step runs first and both steps restore low bits from the original address. With three channel ways and a coarser socket granularity the order reverses, and each step restores low bits from its own input.

Top module: `chan_ilv_strip`

## Requirements
- R1: After reset, `busy`, `done`, `ok` and `err` are low and `chan_addr`, `skt_ways`, `chn_ways` are zero.
- R2: Entry e matches when lo <= address <= hi. Here lo is base word e bits 31:12 followed by 26 zero bits, and hi is wayness word e bits 31:12 followed by 26 one bits. When several entries match, the lowest-numbered entry is used.
- R3: When no entry matches, `done` and `err` pulse together with `ok` low, one clock edge after the edge that samples `start`.
- R4: On success `skt_ways` = 1 << wayness bits 11:10 and `chn_ways` = wayness bits 9:8 plus one.
- R5: The socket granularity code is base bits 5:4 and the channel granularity code is base bits 7:6. Codes 0, 1, 2 and 3 select shifts of 6, 8, 12 and 30.
- R6: The offset word for channel c and entry e sits at word index c*8+e of `ofs_regs`. Its bits 23:4, followed by 26 zero bits, are subtracted from the address modulo 2^46 before any step.
- R7: Normal order: the socket step runs, then the channel step. Each step computes ((x >> g) / ways) << g and ORs in the low g bits of the original, un-offset address.
- R8: Reversed order is used only when the channel ways are 3 and the socket shift is strictly larger than the channel shift. The channel step runs first, then the socket step, and each step takes its low bits from its own input.
- R9: When the channel ways are not 3, `done` with `ok` is high three clock edges after the edge that samples `start`. With three ways the result comes after the serial divide, within 130 edges.
- R10: A `start` that arrives while `busy` is high is ignored. The running request completes with its own result.
- R11: `done` is a one-cycle pulse with exactly one of `ok` or `err`. `busy` rises on the edge after an accepted start and is low while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken when idle |
| sys_addr | input | ADDR_W | System address |
| chan_sel | input | CHAN_W | Channel number, below NUM_CHAN |
| base_regs | input | 32*NUM_RANGE | Base words, entry e at bits 32e+31:32e |
| way_regs | input | 32*NUM_RANGE | Wayness words, same layout |
| ofs_regs | input | 32*NUM_CHAN*NUM_RANGE | Offset words, index c*NUM_RANGE+e |
| busy | output | 1 | Request in progress |
| done | output | 1 | Completion pulse |
| ok | output | 1 | Result valid, with done |
| err | output | 1 | No range matched, with done |
| chan_addr | output | ADDR_W | Channel-local address |
| skt_ways | output | 4 | Socket way count |
| chn_ways | output | 3 | Channel way count |

## Verification
Two events can land on the same edge: a new `start` pulse, and an in-flight request finishing its divide-by-three step or its range lookup. The bench raises `start` with a different address in the middle of a three-way request. It then judges that the completion carries the first request's result and that no second completion follows. A second such test gives `start` on the edge where `done` is high. A behavioural model in the bench, written with integer arithmetic and plain division, predicts each result. That model is compared against the outputs on every clock.

// File: rtl/ilvr_pkg.sv
package ilvr_pkg;
  localparam int REG_W   = 32;
  localparam int FLD_LSB = 12;
  localparam int OFS_LSB = 4;
  localparam int UNIT_SH = 26;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MATCH = 2'd1,
    ST_STEP  = 2'd2,
    ST_DIV   = 2'd3
  } ilvr_state_t;

  // granularity code to shift amount
  function automatic logic [4:0] gran_shift(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd6;
      2'd1:    return 5'd8;
      2'd2:    return 5'd12;
      default: return 5'd30;
    endcase
  endfunction

  // channel way code to shift for the power-of-two cases (code 2 = three ways)
  function automatic logic [1:0] chan_shift(input logic [1:0] code);
    case (code)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      2'd3:    return 2'd2;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/ilvr_range_match.sv
module ilvr_range_match #(
  parameter int ADDR_W    = 46,
  parameter int NUM_RANGE = 8,
  parameter int IDX_W     = $clog2(NUM_RANGE)
) (
  input  logic [ADDR_W-1:0]              addr,
  input  logic [ilvr_pkg::REG_W*NUM_RANGE-1:0] base_regs,
  input  logic [ilvr_pkg::REG_W*NUM_RANGE-1:0] way_regs,
  output logic                           hit,
  output logic [IDX_W-1:0]               idx
);
  localparam int FLD_W = ADDR_W - ilvr_pkg::UNIT_SH;

  logic [NUM_RANGE-1:0] m;

  for (genvar e = 0; e < NUM_RANGE; e++) begin : g_ent
    logic [ADDR_W-1:0] lo, hi;
    assign lo   = {base_regs[e*ilvr_pkg::REG_W+ilvr_pkg::FLD_LSB +: FLD_W], {ilvr_pkg::UNIT_SH{1'b0}}};
    assign hi   = {way_regs[e*ilvr_pkg::REG_W+ilvr_pkg::FLD_LSB +: FLD_W], {ilvr_pkg::UNIT_SH{1'b1}}};
    assign m[e] = (addr >= lo) && (addr <= hi);
  end

  always_comb begin
    hit = |m;
    idx = '0;
    for (int e = NUM_RANGE - 1; e >= 0; e--) begin
      if (m[e]) idx = IDX_W'(e);
    end
  end
endmodule

// File: rtl/ilvr_div3.sv
module ilvr_div3 #(
  parameter int W  = 46,
  parameter int CW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         done,
  output logic [W-1:0] quo
);
  logic [W-1:0]  num;
  logic [W-1:0]  q;
  logic [1:0]    rem;
  logic [CW-1:0] cnt;
  logic          run;
  logic [2:0]    trial;

  assign trial = {rem, num[W-1]};
  assign quo   = q;

  always_ff @(posedge clk) begin
    if (rst) begin
      num  <= '0;
      q    <= '0;
      rem  <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        num <= din;
        q   <= '0;
        rem <= '0;
        cnt <= CW'(W);
        run <= 1'b1;
      end else if (run) begin
        if (trial >= 3'd3) begin
          rem <= 2'(trial - 3'd3);
          q   <= {q[W-2:0], 1'b1};
        end else begin
          rem <= trial[1:0];
          q   <= {q[W-2:0], 1'b0};
        end
        num <= num << 1;
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ilvr_step.sv
module ilvr_step #(
  parameter int ADDR_W = 46
) (
  input  logic [ADDR_W-1:0] opnd,
  input  logic [ADDR_W-1:0] low_src,
  input  logic [4:0]        g,
  input  logic [1:0]        sh,
  input  logic              use3,
  input  logic [ADDR_W-1:0] q3,
  output logic [ADDR_W-1:0] hi_raw,
  output logic [ADDR_W-1:0] res
);
  logic [ADDR_W-1:0] lowmask;
  logic [ADDR_W-1:0] hi_div;

  always_comb begin
    hi_raw  = opnd >> g;
    hi_div  = use3 ? q3 : (hi_raw >> sh);
    lowmask = ~({ADDR_W{1'b1}} << g);
    res     = (hi_div << g) | (low_src & lowmask);
  end
endmodule

// File: rtl/chan_ilv_strip.sv
module chan_ilv_strip
  import ilvr_pkg::*;
#(
  parameter int ADDR_W    = 46,
  parameter int NUM_RANGE = 8,
  parameter int NUM_CHAN  = 3,
  parameter int CHAN_W    = $clog2(NUM_CHAN)
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                start,
  input  logic [ADDR_W-1:0]                   sys_addr,
  input  logic [CHAN_W-1:0]                   chan_sel,
  input  logic [REG_W*NUM_RANGE-1:0]          base_regs,
  input  logic [REG_W*NUM_RANGE-1:0]          way_regs,
  input  logic [REG_W*NUM_CHAN*NUM_RANGE-1:0] ofs_regs,
  output logic                                busy,
  output logic                                done,
  output logic                                ok,
  output logic                                err,
  output logic [ADDR_W-1:0]                   chan_addr,
  output logic [3:0]                          skt_ways,
  output logic [2:0]                          chn_ways
);
  localparam int IDX_W = $clog2(NUM_RANGE);
  localparam int FLD_W = ADDR_W - UNIT_SH;

  ilvr_state_t       st;
  logic [ADDR_W-1:0] a_orig, cur;
  logic [CHAN_W-1:0] ch_q;
  logic [4:0]        g1, g2;
  logic [1:0]        sh1, sh2;
  logic              d3_1, d3_2;
  logic              rev, second;
  logic [3:0]        sw_q;
  logic [2:0]        cw_q;

  logic              hit;
  logic [IDX_W-1:0]  hit_idx;
  logic [REG_W-1:0]  base_w, way_w, ofs_w;
  logic [4:0]        gs, gc;
  logic [1:0]        wcode, csh, ssh;
  logic              cw3, rev_n;
  logic [ADDR_W-1:0] ofs_val;

  logic [4:0]        g_cur;
  logic [1:0]        sh_cur;
  logic              d3_cur;
  logic [ADDR_W-1:0] low_src, hi_raw, step_res, q3;
  logic              div_load, div_done, adv;

  ilvr_range_match #(
    .ADDR_W(ADDR_W), .NUM_RANGE(NUM_RANGE), .IDX_W(IDX_W)
  ) u_match (
    .addr(a_orig), .base_regs(base_regs), .way_regs(way_regs),
    .hit(hit), .idx(hit_idx)
  );

  // fields of the matching entry
  always_comb begin
    int bsel, osel;
    bsel    = int'(hit_idx) * REG_W;
    osel    = (int'(ch_q) * NUM_RANGE + int'(hit_idx)) * REG_W;
    base_w  = base_regs[bsel +: REG_W];
    way_w   = way_regs[bsel +: REG_W];
    ofs_w   = ofs_regs[osel +: REG_W];
    gs      = gran_shift(base_w[5:4]);
    gc      = gran_shift(base_w[7:6]);
    wcode   = way_w[9:8];
    ssh     = way_w[11:10];
    csh     = chan_shift(wcode);
    cw3     = (wcode == 2'd2);
    rev_n   = cw3 && (gs > gc);
    ofs_val = {ofs_w[OFS_LSB +: FLD_W], {UNIT_SH{1'b0}}};
  end

  // per-step selection
  always_comb begin
    g_cur   = second ? g2 : g1;
    sh_cur  = second ? sh2 : sh1;
    d3_cur  = second ? d3_2 : d3_1;
    low_src = rev ? cur : a_orig;
  end

  ilvr_step #(.ADDR_W(ADDR_W)) u_step (
    .opnd(cur), .low_src(low_src), .g(g_cur), .sh(sh_cur),
    .use3(d3_cur), .q3(q3), .hi_raw(hi_raw), .res(step_res)
  );

  assign div_load = (st == ST_STEP) && d3_cur;

  ilvr_div3 #(.W(ADDR_W)) u_div3 (
    .clk(clk), .rst(rst), .load(div_load), .din(hi_raw),
    .done(div_done), .quo(q3)
  );

  assign adv  = ((st == ST_STEP) && !d3_cur) || ((st == ST_DIV) && div_done);
  assign busy = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      a_orig    <= '0;
      cur       <= '0;
      ch_q      <= '0;
      g1        <= '0;
      g2        <= '0;
      sh1       <= '0;
      sh2       <= '0;
      d3_1      <= 1'b0;
      d3_2      <= 1'b0;
      rev       <= 1'b0;
      second    <= 1'b0;
      sw_q      <= '0;
      cw_q      <= '0;
      done      <= 1'b0;
      ok        <= 1'b0;
      err       <= 1'b0;
      chan_addr <= '0;
      skt_ways  <= '0;
      chn_ways  <= '0;
    end else begin
      done <= 1'b0;
      ok   <= 1'b0;
      err  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            a_orig <= sys_addr;
            ch_q   <= chan_sel;
            st     <= ST_MATCH;
          end
        end
        ST_MATCH: begin
          if (!hit) begin
            done <= 1'b1;
            err  <= 1'b1;
            st   <= ST_IDLE;
          end else begin
            cur    <= a_orig - ofs_val;
            rev    <= rev_n;
            second <= 1'b0;
            sw_q   <= 4'd1 << ssh;
            cw_q   <= {1'b0, wcode} + 3'd1;
            if (rev_n) begin
              g1 <= gc; sh1 <= csh; d3_1 <= cw3;
              g2 <= gs; sh2 <= ssh; d3_2 <= 1'b0;
            end else begin
              g1 <= gs; sh1 <= ssh; d3_1 <= 1'b0;
              g2 <= gc; sh2 <= csh; d3_2 <= cw3;
            end
            st <= ST_STEP;
          end
        end
        default: begin
          if (adv) begin
            if (second) begin
              chan_addr <= step_res;
              skt_ways  <= sw_q;
              chn_ways  <= cw_q;
              done      <= 1'b1;
              ok        <= 1'b1;
              st        <= ST_IDLE;
            end else begin
              cur    <= step_res;
              second <= 1'b1;
              st     <= ST_STEP;
            end
          end else if (st == ST_STEP) begin
            st <= ST_DIV;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/chan_ilv_strip_chk.sv
module chan_ilv_strip_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       ok,
  input logic       err,
  input logic [3:0] skt_ways,
  input logic [2:0] chn_ways
);
  // R11: a completion carries exactly one verdict
  p_one_verdict_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> $onehot({ok, err}));

  // R11: no verdict without completion
  p_verdict_with_done_r11: assert property (@(posedge clk) disable iff (rst)
    (ok || err) |-> done);

  // R11: completion lasts one cycle
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11: idle while completing
  p_idle_on_done_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R11: an accepted start makes the block busy
  p_start_taken_r11: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R4: reported way counts are legal
  p_ways_legal_r4: assert property (@(posedge clk) disable iff (rst)
    ok |-> ($onehot(skt_ways) && (chn_ways != 3'd0) && (chn_ways <= 3'd4)));
endmodule

bind chan_ilv_strip chan_ilv_strip_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .ok(ok), .err(err), .skt_ways(skt_ways), .chn_ways(chn_ways)
);

// File: tb/sim_chan_ilv_strip.sv
module sim_chan_ilv_strip;
  localparam int AW = 46;
  localparam int NR = 8;
  localparam int NC = 3;
  localparam longint AMASK = (64'sd1 <<< AW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] sys_addr = '0;
  logic [1:0]    chan_sel = '0;
  logic [32*NR-1:0]    base_regs, way_regs;
  logic [32*NC*NR-1:0] ofs_regs;
  logic          busy, done, ok, err;
  logic [AW-1:0] chan_addr;
  logic [3:0]    skt_ways;
  logic [2:0]    chn_ways;

  logic [31:0] base_m [NR];
  logic [31:0] way_m  [NR];
  logic [31:0] ofs_m  [NC*NR];

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  bit     exp_pend = 0;
  bit     exp_hit;
  longint exp_ca;
  int     exp_sw, exp_cw;
  string  exp_tag;

  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NR; i++) begin
      base_regs[i*32 +: 32] = base_m[i];
      way_regs[i*32 +: 32]  = way_m[i];
    end
    for (int i = 0; i < NC*NR; i++) ofs_regs[i*32 +: 32] = ofs_m[i];
  end

  chan_ilv_strip u0 (
    .clk(clk), .rst(rst), .start(start), .sys_addr(sys_addr),
    .chan_sel(chan_sel), .base_regs(base_regs), .way_regs(way_regs),
    .ofs_regs(ofs_regs), .busy(busy), .done(done), .ok(ok), .err(err),
    .chan_addr(chan_addr), .skt_ways(skt_ways), .chn_ways(chn_ways)
  );

  function automatic int gtab(input int c);
    case (c & 3)
      0: return 6;
      1: return 8;
      2: return 12;
      default: return 30;
    endcase
  endfunction

  function automatic longint strip(input longint x, input int g, input int w,
                                   input longint low);
    longint lm;
    lm = (64'sd1 <<< g) - 1;
    return ((((x >>> g) / w) <<< g) | (low & lm)) & AMASK;
  endfunction

  // behavioural reference of the whole conversion
  function automatic void ref_calc(input longint a, input int ch, output bit hit,
                                   output longint ca, output int sw, output int cw,
                                   output bit slow);
    int e;
    longint lo, hi, off, x;
    int gs, gc;
    hit = 0; ca = 0; sw = 0; cw = 0; slow = 0; e = -1;
    for (int i = 0; i < NR; i++) begin
      lo = longint'(base_m[i][31:12]) <<< 26;
      hi = (longint'(way_m[i][31:12]) <<< 26) | longint'(26'h3ffffff);
      if (e < 0 && a >= lo && a <= hi) e = i;
    end
    if (e < 0) return;
    hit  = 1;
    gs   = gtab(int'(base_m[e][5:4]));
    gc   = gtab(int'(base_m[e][7:6]));
    sw   = 1 << way_m[e][11:10];
    cw   = int'(way_m[e][9:8]) + 1;
    slow = (cw == 3);
    off  = longint'(ofs_m[ch*NR+e][23:4]) <<< 26;
    x    = (a - off) & AMASK;
    if (cw == 3 && gs > gc) begin
      x = strip(x, gc, cw, x);
      x = strip(x, gs, sw, x);
    end else begin
      x = strip(x, gs, sw, a);
      x = strip(x, gc, cw, a);
    end
    ca = x;
  endfunction

  task automatic fail_line(input string tag, input string what,
                           input longint act, input longint exp);
    errors++;
    $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
  endtask

  // per-clock comparison against the model (R10, R11)
  always @(negedge clk) begin
    if (!rst) begin
      if (!done && (ok || err)) fail_line("R11", "verdict without done", {ok, err}, 0);
      if (done && busy) fail_line("R11", "busy at done", busy, 0);
      if (done) begin
        checks++;
        if (!exp_pend) fail_line("R10", "unexpected done", done, 0);
        else if (exp_hit) begin
          if (!ok || err) fail_line(exp_tag, "ok/err", {ok, err}, 2);
          else if (longint'(chan_addr) != exp_ca || int'(skt_ways) != exp_sw ||
                   int'(chn_ways) != exp_cw)
            fail_line(exp_tag, "result", longint'(chan_addr), exp_ca);
        end else if (ok || !err) fail_line(exp_tag, "ok/err", {ok, err}, 1);
        exp_pend = 0;
      end
    end
  end

  // one request; inject > 0 pulses a second start that many cycles in
  task automatic go(input longint a, input int ch, input string tag,
                    input int inject = 0, input longint a2 = 0);
    bit slow;
    int n;
    ref_calc(a, ch, exp_hit, exp_ca, exp_sw, exp_cw, slow);
    exp_tag  = tag;
    exp_pend = 1;
    @(negedge clk);
    sys_addr = a[AW-1:0];
    chan_sel = 2'(ch);
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    if (!busy) fail_line("R11", "busy after start", busy, 1);
    while (!done && n < 500) begin
      if (inject != 0 && n == inject) begin
        sys_addr = a2[AW-1:0];
        start    = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    checks++;
    if (!done) fail_line("R9", "no completion", n, 0);
    else if (!exp_hit) begin
      if (n != 2) fail_line("R3", "error latency", n - 1, 1);
    end else if (!slow) begin
      if (n != 4) fail_line("R9", "latency", n - 1, 3);
    end else if (n > 131) fail_line("R9", "slow latency", n - 1, 130);
    @(negedge clk);
    if (done) fail_line("R10", "second completion", done, 0);
  endtask

  initial begin
    longint a;
    for (int c = 0; c < NC; c++)
      for (int e = 0; e < NR; e++)
        ofs_m[c*NR+e] = 32'(((e*5 + c*3) & 255) << 4);
    base_m[0] = (0 << 12) | (1 << 6) | (0 << 4);  way_m[0] = (3 << 12) | (1 << 10) | (1 << 8);
    base_m[1] = (4 << 12) | (0 << 6) | (2 << 4);  way_m[1] = (15 << 12) | (2 << 10) | (2 << 8);
    base_m[2] = (16 << 12) | (1 << 6) | (0 << 4); way_m[2] = (31 << 12) | (0 << 10) | (2 << 8);
    base_m[3] = (64 << 12) | (1 << 6) | (1 << 4); way_m[3] = (67 << 12) | (1 << 10) | (2 << 8);
    base_m[4] = (32 << 12) | (2 << 6) | (3 << 4); way_m[4] = (47 << 12) | (3 << 10) | (3 << 8);
    base_m[5] = (32 << 12) | (3 << 6) | (1 << 4); way_m[5] = (63 << 12) | (0 << 10) | (0 << 8);
    base_m[6] = (100 << 12); way_m[6] = (99 << 12);
    base_m[7] = (100 << 12); way_m[7] = (99 << 12);

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (busy || done || ok || err || chan_addr != '0 || skt_ways != '0 || chn_ways != '0)
      fail_line("R1", "reset state", {busy, done, ok, err}, 0);

    go(64'h0000_0123_4567 & ((64'sd4 <<< 26) - 1), 0, "R7");
    go((64'sd4 <<< 26) - 1, 1, "R2");
    go(64'sd4 <<< 26, 2, "R2");
    go((64'sd5 <<< 26) | 64'h2a_5f3c, 2, "R8");
    go((64'sd9 <<< 26) | 64'h1fe_d0c1, 0, "R8");
    go((64'sd20 <<< 26) | 64'h3ab_cdef, 1, "R7");
    go((64'sd65 <<< 26) | 64'h12_3457, 0, "R8");
    go((64'sd33 <<< 26) | 64'h77_1234, 2, "R2");
    go((64'sd50 <<< 26) | 64'h5, 1, "R5");
    go((64'sd44 <<< 26) | 64'h3ff_fffc, 0, "R4");
    go((64'sd2 <<< 26) | 64'h6, 2, "R6");
    go(64'sd70 <<< 26, 0, "R3");
    go(AMASK, 1, "R3");
    go((64'sd6 <<< 26) | 64'h55_aa11, 1, "R10", 10, 64'sd70 <<< 26);
    go(64'sd71 <<< 26, 2, "R10", 1, 64'sd1 <<< 26);
    for (int k = 0; k < 60; k++) begin
      a = (longint'($urandom_range(71, 0)) <<< 26) | longint'($urandom & 32'h3ffffff);
      go(a, int'($urandom_range(2, 0)), "R7");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    checks++;
    errors++;
    $display("FAIL R9 watchdog actual=%0d expected=%0d", cycles, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule